// File: doc/BRIEF.md
# Programmable Burst Column Sequencer

This block produces the column addresses of one synchronous DRAM burst, one per clock. A memory controller loads a small mode word that fixes how many columns a burst covers, the order they are visited in, and how many clocks pass between a column beat and its read data. It then issues burst-start strobes carrying a starting column and a bank bit. The block walks the columns of that burst on `col_addr`, marks every live beat with `col_valid`, and raises `rd_valid` a programmed number of enabled clocks after each beat so the controller knows when read data should arrive.

Fixed bursts stay inside an aligned block of 1, 2, 4 or 8 columns and wrap within it, either counting up or following an exclusive-or order. A full-page burst counts up through all 256 columns of the row, wrapping from 255 to 0, until a stop strobe ends it. A new start always takes over at once. Dropping the clock enable freezes every register, output and the read-valid pipeline until it returns.

Top module: `burst_col_seq`

## Requirements
- R1: After reset `col_valid` and `rd_valid` are 0 and the mode is: one-column bursts, up-counting order, read latency 2.
- R2: A start seen on an enabled edge makes `col_valid` 1 in the next cycle with `col_addr` equal to the start column and `col_bank` equal to the start bank bit.
- R3: Mode word bits [2:0] give the burst length: 000 = 1, 001 = 2, 010 = 4, 011 = 8, 111 = full page; a fixed burst shows exactly that many beats and then `col_valid` returns to 0.
- R4: With mode bit [3] = 0, beat n of a fixed burst has the upper column bits of the start column and low bits equal to (start + n) modulo the length.
- R5: With mode bit [3] = 1, beat n of a fixed burst has the upper bits of the start column and low bits equal to the start column XOR n.
- R6: A full-page burst always counts up by one per beat (bit [3] is ignored), wraps from 255 to 0, and runs until a stop is seen.
- R7: A stop seen on an enabled edge ends any burst, so `col_valid` is 0 in the next cycle; if a start is seen on the same edge the start wins.
- R8: A start seen while a burst is running abandons it and restarts the sequence from the new column and bank.
- R9: A mode load is accepted only on an enabled edge where `col_valid` is 0; a load made during a burst leaves the mode unchanged. A load on the same edge as a start from idle applies to that burst.
- R10: A mode word with a length code of 100, 101 or 110, or with a latency field bits [6:4] other than 010 (latency 2) or 011 (latency 3), is dropped as a whole and the previous mode stays.
- R11: `rd_valid` equals the value `col_valid` had exactly L enabled edges earlier, L being the programmed latency of 2 or 3.
- R12: While `cke` is 0 at an edge, no register changes: addresses, flags and the read-valid pipeline hold, and start, stop and mode-load strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; 0 freezes the block |
| mode_ld | input | 1 | Mode-load strobe |
| mode_word | input | 7 | Mode word: [6:4] latency, [3] order, [2:0] length |
| start | input | 1 | Burst-start strobe |
| start_col | input | 8 | Starting column of the burst |
| start_bank | input | 1 | Bank bit for the burst |
| stop | input | 1 | Burst-stop strobe |
| col_addr | output | 8 | Current column address |
| col_bank | output | 1 | Bank of the current burst |
| col_valid | output | 1 | A column beat is present this cycle |
| rd_valid | output | 1 | Read data of an earlier beat is due this cycle |

## Verification
The two functions that can meet in one cycle are burst termination and burst start: a stop or the natural last beat can coincide with a new start, and a start can land in the middle of a running burst. The bench provokes this by raising start and stop together on the first beat of a four-column burst and by restarting an eight-column burst on its third beat, then judges that the next cycle carries the new start column and bank and that the remaining beats follow the new column's block. Independently, a running read-valid model shifts the sampled `col_valid` history on every enabled edge, so overlapping bursts, freezes and restarts are all judged against the latency rule cycle by cycle.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             mode_ld,
  input  logic [6:0]       mode_word,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_bank,
  input  logic             stop,
  output logic [COL_W-1:0] col_addr,
  output logic             col_bank,
  output logic             col_valid,
  output logic             rd_valid
);

  logic [2:0]       len_code;
  logic             ilv;
  logic             lat3;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] cnt;
  logic [2:0]       pipe;
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] next_addr;

  wire             full     = (len_code == 3'b111);
  wire             last     = !full && (cnt == mask);
  wire [COL_W-1:0] next_cnt = cnt + 1'b1;
  wire             len_ok   = (mode_word[2] == 1'b0) || (mode_word[2:0] == 3'b111);
  wire             lat_ok   = (mode_word[6:5] == 2'b01);
  wire             take_mode = mode_ld && !col_valid && len_ok && lat_ok;

  always_comb begin
    case (len_code)
      3'b000:  mask = '0;
      3'b001:  mask = COL_W'(1);
      3'b010:  mask = COL_W'(3);
      3'b011:  mask = COL_W'(7);
      default: mask = '1;
    endcase
  end

  always_comb begin
    if (ilv && !full) next_addr = (base & ~mask) | ((base ^ next_cnt) & mask);
    else              next_addr = (base & ~mask) | ((base + next_cnt) & mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_code  <= 3'b000;
      ilv       <= 1'b0;
      lat3      <= 1'b0;
      base      <= '0;
      cnt       <= '0;
      col_addr  <= '0;
      col_bank  <= 1'b0;
      col_valid <= 1'b0;
      pipe      <= '0;
    end else if (cke) begin
      if (start) begin
        base      <= start_col;
        cnt       <= '0;
        col_addr  <= start_col;
        col_bank  <= start_bank;
        col_valid <= 1'b1;
      end else if (col_valid) begin
        if (stop || last) begin
          col_valid <= 1'b0;
        end else begin
          cnt      <= next_cnt;
          col_addr <= next_addr;
        end
      end
      if (take_mode) begin
        len_code <= mode_word[2:0];
        ilv      <= mode_word[3];
        lat3     <= mode_word[4];
      end
      pipe <= {pipe[1:0], col_valid};
    end
  end

  assign rd_valid = lat3 ? pipe[2] : pipe[1];

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cke && start |=> col_valid && col_addr == $past(start_col) && col_bank == $past(start_bank));

  assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cke && stop && !start |=> !col_valid);

  assert_fullpage_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cke && col_valid && full && !start && !stop |=> col_valid && col_addr == $past(col_addr) + 1'b1);

  assert_block_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cke && col_valid && !start && !stop && !last && !mode_ld
    |=> col_valid && ((col_addr ^ $past(col_addr)) & ~mask) == '0);

  assert_mode_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cke && mode_ld && col_valid |=> $stable(len_code) && $stable(ilv) && $stable(lat3));

  assert_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(col_addr) && $stable(col_valid) && $stable(col_bank) && $stable(rd_valid));

endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1;
  logic       mode_ld = 1'b0;
  logic [6:0] mode_word = '0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic       start_bank = 1'b0;
  logic       stop = 1'b0;
  logic [7:0] col_addr;
  logic       col_bank;
  logic       col_valid;
  logic       rd_valid;

  int checks = 0;
  int fails = 0;

  int m_len = 1;
  bit m_il  = 1'b0;
  int m_lat = 2;

  logic [2:0] h = '0;
  logic       last_cv = 1'b0;
  logic       edge_en = 1'b0;
  bit         rd_on = 1'b0;

  always #10 clk = ~clk;

  burst_col_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .mode_ld(mode_ld), .mode_word(mode_word),
    .start(start), .start_col(start_col), .start_bank(start_bank), .stop(stop),
    .col_addr(col_addr), .col_bank(col_bank), .col_valid(col_valid), .rd_valid(rd_valid)
  );

  localparam int NV = 11;
  localparam logic [15:0] VEC [NV] = '{
    {7'h20, 1'b0, 8'h00}, {7'h21, 1'b1, 8'h05}, {7'h22, 1'b0, 8'h13},
    {7'h23, 1'b1, 8'h2D}, {7'h2A, 1'b0, 8'h36}, {7'h2B, 1'b1, 8'h7B},
    {7'h33, 1'b0, 8'h9E}, {7'h3B, 1'b1, 8'hC1}, {7'h39, 1'b0, 8'hF7},
    {7'h27, 1'b1, 8'hFC}, {7'h2F, 1'b0, 8'h81}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_addr(input logic [7:0] c, input int n);
    logic [7:0] mk;
    mk = 8'(m_len - 1);
    if (m_il && m_len != 256) return (c & ~mk) | ((c ^ 8'(n)) & mk);
    return (c & ~mk) | (8'(c + 8'(n)) & mk);
  endfunction

  always @(posedge clk) edge_en <= cke;

  always @(negedge clk) begin
    if (rd_on) begin
      if (edge_en) h = {h[1:0], last_cv};
      chk(rd_valid === (m_lat == 3 ? h[2] : h[1]), "R11 rd_valid", rd_valid,
          m_lat == 3 ? h[2] : h[1]);
      last_cv = col_valid;
    end
  end

  task automatic step();
    @(negedge clk);
    start = 1'b0; stop = 1'b0; mode_ld = 1'b0;
  endtask

  task automatic issue_start(input logic [7:0] c, input logic b);
    start = 1'b1; start_col = c; start_bank = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic set_mode(input logic [6:0] w, input string req);
    step();
    mode_ld = 1'b1; mode_word = w;
    if ((w[2] == 1'b0 || w[2:0] == 3'b111) && w[6:5] == 2'b01) begin
      case (w[2:0])
        3'b000: m_len = 1;
        3'b001: m_len = 2;
        3'b010: m_len = 4;
        3'b011: m_len = 8;
        default: m_len = 256;
      endcase
      m_il  = w[3];
      m_lat = w[4] ? 3 : 2;
    end
    step();
  endtask

  task automatic expect_beats(input logic [7:0] c, input logic b, input int first, input int cnt,
                              input string req);
    for (int n = first; n < first + cnt; n++) begin
      step();
      chk(col_valid === 1'b1, req, col_valid, 1);
      chk(col_addr === exp_addr(c, n), req, col_addr, exp_addr(c, n));
      chk(col_bank === b, req, col_bank, b);
    end
  endtask

  task automatic expect_idle(input string req);
    step();
    chk(col_valid === 1'b0, req, col_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(col_valid === 1'b0, "R1 reset col_valid", col_valid, 0);
    chk(rd_valid === 1'b0, "R1 reset rd_valid", rd_valid, 0);
    rst_n = 1'b1;
    rd_on = 1'b1;
    idle(2);

    // R1: default mode is a single beat, latency 2
    issue_start(8'h37, 1'b0);
    expect_beats(8'h37, 1'b0, 0, 1, "R1 default beat");
    expect_idle("R1 default length");
    idle(4);

    // Vector table: R3 R4 R5 R6 R11
    for (int v = 0; v < NV; v++) begin
      logic [7:0] c;
      logic b;
      int nb;
      c = VEC[v][7:0];
      b = VEC[v][8];
      set_mode(VEC[v][15:9], "R3");
      idle(1);
      issue_start(c, b);
      nb = (m_len == 256) ? 260 : m_len;
      expect_beats(c, b, 0, nb, m_len == 256 ? "R6 full page" : (m_il ? "R5 interleave" : "R4 sequential"));
      if (m_len == 256) stop = 1'b1;
      expect_idle(m_len == 256 ? "R6 stop" : "R3 length end");
      idle(4);
    end

    // R8: restart in the middle of a burst
    set_mode(7'h23, "R8");
    issue_start(8'h10, 1'b0);
    expect_beats(8'h10, 1'b0, 0, 3, "R8 first burst");
    issue_start(8'h45, 1'b1);
    expect_beats(8'h45, 1'b1, 0, 8, "R8 restarted burst");
    expect_idle("R8 end");
    idle(4);

    // R7: stop during a fixed burst
    issue_start(8'h50, 1'b0);
    expect_beats(8'h50, 1'b0, 0, 2, "R7 before stop");
    stop = 1'b1;
    expect_idle("R7 stop ends burst");
    idle(4);

    // R7: start and stop together, start wins
    set_mode(7'h22, "R7");
    issue_start(8'h60, 1'b0);
    expect_beats(8'h60, 1'b0, 0, 1, "R7 first");
    issue_start(8'h8A, 1'b1);
    stop = 1'b1;
    expect_beats(8'h8A, 1'b1, 0, 4, "R7 start wins over stop");
    expect_idle("R7 end");
    idle(4);

    // R9: mode load during a burst is ignored
    set_mode(7'h21, "R9");
    issue_start(8'h20, 1'b0);
    expect_beats(8'h20, 1'b0, 0, 1, "R9 burst");
    mode_ld = 1'b1; mode_word = 7'h23;
    expect_beats(8'h20, 1'b0, 1, 1, "R9 burst");
    expect_idle("R9 end");
    idle(4);
    issue_start(8'h30, 1'b0);
    expect_beats(8'h30, 1'b0, 0, 2, "R9 mode kept");
    expect_idle("R9 length kept at 2");
    idle(4);

    // R10: reserved encodings dropped
    set_mode(7'h24, "R10");
    set_mode(7'h43, "R10");
    set_mode(7'h0B, "R10");
    idle(2);
    issue_start(8'hA3, 1'b1);
    expect_beats(8'hA3, 1'b1, 0, 2, "R10 mode unchanged");
    expect_idle("R10 length still 2");
    idle(4);

    // R12: clock enable low freezes everything
    set_mode(7'h23, "R12");
    issue_start(8'h18, 1'b0);
    expect_beats(8'h18, 1'b0, 0, 3, "R12 before freeze");
    cke = 1'b0;
    step();
    chk(col_valid === 1'b1 && col_addr === 8'h1A, "R12 frozen", col_addr, 8'h1A);
    issue_start(8'hEE, 1'b1);
    stop = 1'b1;
    step();
    chk(col_valid === 1'b1 && col_addr === 8'h1A, "R12 strobes ignored", col_addr, 8'h1A);
    step();
    chk(col_bank === 1'b0 && col_addr === 8'h1A, "R12 frozen bank", col_addr, 8'h1A);
    cke = 1'b1;
    expect_beats(8'h18, 1'b0, 3, 5, "R12 resumed");
    expect_idle("R12 end");
    idle(5);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule